// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element

This block is one processing element of a SIMD mesh that works on one bit at a time. Every element in an array receives the same instruction. In each cycle an element picks two operand bits, `i` and `j`, and also reads its accumulator flag `F`. These three bits index a 16-bit truth table carried in the instruction. The table yields two bits: a new accumulator value and a destination bit `d`. Multi-bit arithmetic is built from a chain of such steps, one bit per cycle, with `F` holding the carry.

Each element holds eight flag bits and a bit-addressed local memory. An operand can come from one of three places:
- a flag bit,
- the memory bit selected by the single address field,
- the output flag of one of the eight neighbours.

The destination can be a flag, the addressed memory bit, or nowhere. An instruction can be made conditional on three enables: the element's active flag, a row enable input and a column enable input. The output flag `X` goes to the neighbours and is also the element's response bit.

Top module: `bsimd_pe`

## Requirements
- R1: A synchronous reset clears all eight flags, so `resp_x` reads 0 in the cycle after reset. After reset, the active flag and the accumulator also read 0.
- R2: The instruction word is packed as {func[15:0], use_act, use_row, use_col, src_i[4:0], src_j[4:0], dst[3:0], addr[ADDR_W-1:0]}, with the MSB first. For k = {i,j,F}, bit func[15-2k] is the new F and bit func[14-2k] is d.
- R3: On an executed instruction, F takes the new-F bit and the selected destination takes d. When dst selects F (code 7), d wins over the new-F bit.
- R4: Source codes 0..7, and destination codes 0..7, select the flags in this order: X, Y, Z, T, U, V, A, F. Source codes 17..31 read 0.
- R5: Source codes 8..15 read the neighbour inputs nbr_in[0..7] in the order N, NE, E, SE, S, SW, W, NW. The value used is the one present on the input during that cycle.
- R6: Source code 16 reads memory bit `addr`, and destination code 8 writes memory bit `addr`. No other memory bit changes.
- R7: Destination codes 9..15 discard d, while F is still updated.
- R8: With use_act=1 and A=0, the instruction changes no state.
- R9: With use_row=1, the instruction executes only when row_en=1. With use_col=1, it executes only when col_en=1.
- R10: With instr_en=0, no state changes.
- R11: `resp_x` is the registered X flag. It shows the effect of an instruction one clock edge after that instruction is presented.
- R12: With func = 16'h166B, d is the sum and F is the carry of i+j+F, so a multi-bit add runs one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_en | input | 1 | Instruction issued this cycle |
| instr | input | 33+ADDR_W | Broadcast instruction word |
| nbr_in | input | 8 | Neighbour output flags, N..NW at bits 0..7 |
| row_en | input | 1 | Row mask line selects this element |
| col_en | input | 1 | Column mask line selects this element |
| resp_x | output | 1 | Output/response flag X, also fed to neighbours |

## Verification
Every executed instruction commits at the clock edge where it is presented, so `resp_x` carries the result one edge later. The bench drives each instruction on a falling edge and checks `resp_x` on the next falling edge, which is exactly one rising edge later. Results that land in other flags or in memory are not visible directly. They are checked by a follow-up copy instruction that moves the bit into X, and that check happens one further cycle on. Gated, idle and discarded results are checked the same way: the bench reads back the state that a faulty design would have changed.

// File: rtl/bsimd_pkg.sv
package bsimd_pkg;
  localparam int FUNC_W = 16;
  localparam int SRC_W  = 5;
  localparam int DST_W  = 4;
  localparam int NFLAG  = 8;
  localparam int NDIR   = 8;
  localparam int CTRL_W = FUNC_W + 3 + 2*SRC_W + DST_W;

  localparam int FLG_X = 0;
  localparam int FLG_A = 6;
  localparam int FLG_F = 7;

  localparam logic [SRC_W-1:0] SRC_NBR0 = 5'd8;
  localparam logic [SRC_W-1:0] SRC_MEM  = 5'd16;
  localparam logic [DST_W-1:0] DST_MEM  = 4'd8;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic              use_act;
    logic              use_row;
    logic              use_col;
    logic [SRC_W-1:0]  src_i;
    logic [SRC_W-1:0]  src_j;
    logic [DST_W-1:0]  dst;
  } ctrl_t;
endpackage

// File: rtl/bsimd_opsel.sv
module bsimd_opsel
  import bsimd_pkg::*;
(
  input  logic [SRC_W-1:0] sel,
  input  logic [NFLAG-1:0] flags,
  input  logic [NDIR-1:0]  nbr,
  input  logic             mem_bit,
  output logic             op
);
  always_comb begin
    op = 1'b0;
    if (sel < SRC_NBR0)
      op = flags[sel[2:0]];
    else if (sel < SRC_MEM)
      op = nbr[sel[2:0]];
    else if (sel == SRC_MEM)
      op = mem_bit;
  end
endmodule

// File: rtl/bsimd_alu.sv
module bsimd_alu
  import bsimd_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  input  logic              op_i,
  input  logic              op_j,
  input  logic              acc,
  output logic              f_new,
  output logic              d_out
);
  logic [2:0] k;
  logic [3:0] hi_pos;

  assign k      = {op_i, op_j, acc};
  assign hi_pos = 4'd15 - {k, 1'b0};

  always_comb begin
    f_new = func[hi_pos];
    d_out = func[hi_pos - 4'd1];
  end
endmodule

// File: rtl/bsimd_store.sv
module bsimd_store
  import bsimd_pkg::*;
#(
  parameter int MEM_BITS = 256,
  localparam int ADDR_W  = $clog2(MEM_BITS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              exec,
  input  logic              f_new,
  input  logic              d_in,
  input  logic [DST_W-1:0]  dst,
  input  logic [ADDR_W-1:0] addr,
  output logic [NFLAG-1:0]  flags_q,
  output logic              mem_rd
);
  logic mem [MEM_BITS];

  always_ff @(posedge clk) begin
    if (exec && dst == DST_MEM)
      mem[addr] <= d_in;
  end

  assign mem_rd = mem[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (exec) begin
      flags_q[FLG_F] <= f_new;
      if (dst < DST_W'(NFLAG))
        flags_q[dst[2:0]] <= d_in;
    end
  end
endmodule

// File: rtl/bsimd_pe.sv
module bsimd_pe
  import bsimd_pkg::*;
#(
  parameter int MEM_BITS = 256,
  localparam int ADDR_W  = $clog2(MEM_BITS),
  localparam int INSTR_W = CTRL_W + ADDR_W
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_en,
  input  logic [INSTR_W-1:0] instr,
  input  logic [NDIR-1:0]    nbr_in,
  input  logic               row_en,
  input  logic               col_en,
  output logic               resp_x
);
  ctrl_t             ctl;
  logic [ADDR_W-1:0] addr;
  logic [NFLAG-1:0]  flags_q;
  logic              mem_rd;
  logic              exec_en;
  logic              f_new;
  logic              d_res;
  logic [1:0]        ops;
  logic [DST_W-1:0]  dst_sel;

  assign ctl     = ctrl_t'(instr[INSTR_W-1:ADDR_W]);
  assign addr    = instr[ADDR_W-1:0];
  assign dst_sel = ctl.dst;

  assign exec_en = instr_en
                 && (!ctl.use_act || flags_q[FLG_A])
                 && (!ctl.use_row || row_en)
                 && (!ctl.use_col || col_en);

  for (genvar g = 0; g < 2; g++) begin : g_opsel
    bsimd_opsel u_sel (
      .sel     ((g == 0) ? ctl.src_i : ctl.src_j),
      .flags   (flags_q),
      .nbr     (nbr_in),
      .mem_bit (mem_rd),
      .op      (ops[g])
    );
  end

  bsimd_alu u_alu (
    .func  (ctl.func),
    .op_i  (ops[0]),
    .op_j  (ops[1]),
    .acc   (flags_q[FLG_F]),
    .f_new (f_new),
    .d_out (d_res)
  );

  bsimd_store #(.MEM_BITS(MEM_BITS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .exec    (exec_en),
    .f_new   (f_new),
    .d_in    (d_res),
    .dst     (dst_sel),
    .addr    (addr),
    .flags_q (flags_q),
    .mem_rd  (mem_rd)
  );

  assign resp_x = flags_q[FLG_X];
endmodule

// File: rtl/bsimd_pe_chk.sv
module bsimd_pe_chk
  import bsimd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             instr_en,
  input logic             use_act,
  input logic [NFLAG-1:0] flags,
  input logic             exec_en,
  input logic             f_new,
  input logic             d_res,
  input logic [DST_W-1:0] dst,
  input logic             resp_x
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> flags == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_en |=> $stable(flags));

  // R8
  act_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_en && use_act && !flags[FLG_A]) |=> $stable(flags));

  // R3
  acc_update_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && dst != DST_W'(FLG_F)) |=> flags[FLG_F] == $past(f_new));

  // R11
  resp_update_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_en && dst == DST_W'(FLG_X)) |=> resp_x == $past(d_res));
endmodule

bind bsimd_pe bsimd_pe_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .instr_en (instr_en),
  .use_act  (ctl.use_act),
  .flags    (flags_q),
  .exec_en  (exec_en),
  .f_new    (f_new),
  .d_res    (d_res),
  .dst      (dst_sel),
  .resp_x   (resp_x)
);

// File: tb/bsimd_pe_bench.sv
module bsimd_pe_bench;
  localparam int ADDR_W  = 8;
  localparam int INSTR_W = 33 + ADDR_W;

  localparam logic [15:0] F_ONE  = 16'h7777;
  localparam logic [15:0] F_ZERO = 16'h2222;
  localparam logic [15:0] F_CPY  = 16'h2277;
  localparam logic [15:0] F_LDF  = 16'h00FF;
  localparam logic [15:0] F_ADD  = 16'h166B;
  localparam logic [15:0] F_AND  = 16'h2227;
  localparam logic [15:0] F_CLR  = 16'h0000;

  typedef struct packed {
    logic [7:0]  req;
    logic        en;
    logic [15:0] func;
    logic        act;
    logic        row;
    logic        col;
    logic [4:0]  si;
    logic [4:0]  sj;
    logic [3:0]  dst;
    logic [7:0]  addr;
    logic [7:0]  nbr;
    logic        rsel;
    logic        csel;
    logic        exp_x;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  1'b1, F_ONE,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R2
    '{8'd2,  1'b1, F_ZERO, 1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R2
    '{8'd5,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd10, 5'd0, 4'd0, 8'd0,   8'h04, 1'b0,1'b0, 1'b1}, // R5 E
    '{8'd5,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd14, 5'd0, 4'd0, 8'd0,   8'hBF, 1'b0,1'b0, 1'b0}, // R5 W
    '{8'd6,  1'b1, F_ONE,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd8, 8'd200, 8'h00, 1'b0,1'b0, 1'b0}, // R6
    '{8'd6,  1'b1, F_ZERO, 1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd8, 8'd255, 8'h00, 1'b0,1'b0, 1'b0}, // R6
    '{8'd6,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd16, 5'd0, 4'd0, 8'd200, 8'h00, 1'b0,1'b0, 1'b1}, // R6
    '{8'd6,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd16, 5'd0, 4'd0, 8'd255, 8'h00, 1'b0,1'b0, 1'b0}, // R6
    '{8'd6,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd16, 5'd0, 4'd0, 8'd200, 8'h00, 1'b0,1'b0, 1'b1}, // R6
    '{8'd7,  1'b1, F_ZERO, 1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd9, 8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R7
    '{8'd7,  1'b1, F_LDF,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd15,8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R7 F=1
    '{8'd2,  1'b1, F_ZERO, 1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R2
    '{8'd12, 1'b1, F_ADD,  1'b0,1'b0,1'b0, 5'd1,  5'd2, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R12 0+0+1
    '{8'd12, 1'b1, F_ADD,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd1, 8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R12 1+1+0
    '{8'd12, 1'b1, F_ZERO, 1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R12
    '{8'd12, 1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd7,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R12 carry
    '{8'd12, 1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd1,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R12 sum
    '{8'd8,  1'b1, F_ONE,  1'b1,1'b0,1'b0, 5'd0,  5'd0, 4'd1, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R8
    '{8'd8,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd1,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R8 Y kept
    '{8'd4,  1'b1, F_ONE,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd6, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R4 A=1
    '{8'd8,  1'b1, F_ONE,  1'b1,1'b0,1'b0, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R8
    '{8'd9,  1'b1, F_ZERO, 1'b0,1'b1,1'b0, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b1, 1'b1}, // R9
    '{8'd9,  1'b1, F_ZERO, 1'b0,1'b1,1'b1, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b1,1'b0, 1'b1}, // R9
    '{8'd9,  1'b1, F_ZERO, 1'b0,1'b1,1'b1, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b1,1'b1, 1'b0}, // R9
    '{8'd10, 1'b0, F_ONE,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R10
    '{8'd3,  1'b1, F_CLR,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd9, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R3 F=0
    '{8'd3,  1'b1, F_ONE,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd7, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R3 d wins
    '{8'd3,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd7,  5'd0, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R3
    '{8'd4,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd20, 5'd0, 4'd0, 8'd0,   8'hFF, 1'b0,1'b0, 1'b0}, // R4 unused code
    '{8'd5,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd15, 5'd0, 4'd0, 8'd0,   8'h80, 1'b0,1'b0, 1'b1}, // R5 NW
    '{8'd5,  1'b1, F_CPY,  1'b0,1'b0,1'b0, 5'd8,  5'd0, 4'd0, 8'd0,   8'hFE, 1'b0,1'b0, 1'b0}, // R5 N
    '{8'd4,  1'b1, F_ONE,  1'b0,1'b0,1'b0, 5'd0,  5'd0, 4'd1, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}, // R4 Y=1
    '{8'd2,  1'b1, F_AND,  1'b0,1'b0,1'b0, 5'd1,  5'd6, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b1}, // R2 Y&A
    '{8'd2,  1'b1, F_AND,  1'b0,1'b0,1'b0, 5'd1,  5'd2, 4'd0, 8'd0,   8'h00, 1'b0,1'b0, 1'b0}  // R2 Y&Z
  };

  logic               clk = 1'b0;
  logic               rst;
  logic               instr_en;
  logic [INSTR_W-1:0] instr;
  logic [7:0]         nbr_in;
  logic               row_en;
  logic               col_en;
  logic               resp_x;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  bsimd_pe u_bsimd_pe (
    .clk(clk), .rst(rst), .instr_en(instr_en), .instr(instr),
    .nbr_in(nbr_in), .row_en(row_en), .col_en(col_en), .resp_x(resp_x)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input int req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d resp_x actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    instr_en = v.en;
    instr    = {v.func, v.act, v.row, v.col, v.si, v.sj, v.dst, v.addr};
    nbr_in   = v.nbr;
    row_en   = v.rsel;
    col_en   = v.csel;
    @(negedge clk);
    instr_en = 1'b0;
    check(int'(v.req), resp_x, v.exp_x);
  endtask

  function automatic vec_t mk(input logic [15:0] f, input logic a,
                              input logic [4:0] si, input logic [3:0] d,
                              input logic e);
    vec_t v;
    v = '0;
    v.req = 8'd1; v.en = 1'b1; v.func = f; v.act = a;
    v.si = si; v.dst = d; v.exp_x = e;
    return v;
  endfunction

  initial begin
    rst = 1'b1; instr_en = 1'b0; instr = '0; nbr_in = '0;
    row_en = 1'b0; col_en = 1'b0;
    repeat (2) @(negedge clk);
    check(1, resp_x, 1'b0); // R1 reset state
    rst = 1'b0;

    for (int n = 0; n < NV; n++) step(VEC[n]);

    // R1 reset in mid-run after X, A and F were set
    step(mk(F_ONE, 1'b0, 5'd0, 4'd0, 1'b1));
    step(mk(F_ONE, 1'b0, 5'd0, 4'd7, 1'b1));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(1, resp_x, 1'b0);                      // R1 X cleared
    step(mk(F_ONE, 1'b1, 5'd0, 4'd0, 1'b0));     // R1 A cleared, gated
    step(mk(F_ONE, 1'b0, 5'd0, 4'd0, 1'b1));
    step(mk(F_CPY, 1'b0, 5'd7, 4'd0, 1'b0));     // R1 F cleared

    // R11 result visible exactly one edge after issue
    @(negedge clk);
    instr_en = 1'b1;
    instr = {F_ONE, 3'b000, 5'd0, 5'd0, 4'd0, 8'd0};
    check(11, resp_x, 1'b0);
    @(negedge clk);
    instr_en = 1'b0;
    check(11, resp_x, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule